// File: doc/BRIEF.md
# Masked Vector Compare-to-Mask Unit

This block takes two 512-bit integer vectors, splits them into lanes of 32 or 64 bits, compares each pair of lanes, and returns one result bit per lane packed into a 16-bit mask word. A 3-bit predicate code picks the comparison. Six codes are relational tests and two are constants. A sign control makes the lanes compare as two's-complement or as unsigned numbers.

A write mask is supplied with every operation, together with a small selector. The selector value zero means "no masking", and every lane is then enabled whatever the mask input holds. Any other selector value makes the supplied mask decide which lanes may report true. Disabled lanes always report zero.

Operations enter through a valid/ready handshake. The registered result leaves through a second valid/ready handshake one cycle after acceptance. The result register holds its value while the consumer stalls.

Top module: `vcmp_mask_unit`

## Requirements
- R1: The predicate code selects the lane test as follows: 0 equal, 1 less-than, 2 less-or-equal, 3 constant false, 4 not-equal, 5 greater-or-equal, 6 greater-than, 7 constant true.
- R2: With `laneWide` low, lane i occupies bits [32i+31:32i] of both operands and its result is bit i of `outMask`, for i from 0 to 15.
- R3: With `laneWide` high, lane i occupies bits [64i+63:64i], its result is bit i for i from 0 to 7, and bits 15 to 8 of `outMask` are zero.
- R4: With `cmpSigned` high, lanes compare as two's-complement integers. With it low, they compare as unsigned integers.
- R5: When `maskSel` is nonzero, a result bit is forced to zero wherever the matching bit of `maskIn` is zero.
- R6: When `maskSel` is zero, all lanes are enabled and `maskIn` has no effect on the result.
- R7: Codes 3 and 7 ignore the operand values. Code 7 yields exactly the enabled lanes of the active lane count, and code 3 yields zero.
- R8: An operation is accepted on a clock edge where `inValid` and `inReady` are both high. Its result appears on `outMask`, with `outValid` high, after that edge.
- R9: While `outValid` is high and `outReady` is low, `inReady` is low, and `outValid` and `outMask` stay unchanged. `inReady` is high whenever `outValid` is low or `outReady` is high.
- R10: After reset, `outValid` is low, `outMask` is zero, and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit can take an operation |
| vecA | input | 512 | First operand vector |
| vecB | input | 512 | Second operand vector |
| pred | input | 3 | Predicate code |
| laneWide | input | 1 | 1 = 64-bit lanes, 0 = 32-bit lanes |
| cmpSigned | input | 1 | 1 = signed compare, 0 = unsigned |
| maskSel | input | 3 | Write-mask selector, 0 = unmasked |
| maskIn | input | 16 | Write-mask value |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outMask | output | 16 | Packed per-lane result |

## Verification
A wrong lane slice or predicate decode shows up as a wrong bit in `outMask` on the first result after the faulty operation. The bench compares every such result on the clock that follows acceptance. A fault in the handshake state shows as `outValid` or `inReady` differing from the reference model in the same cycle. It can also show as a result that changes or disappears during a stall, which the randomly stalled consumer exposes within a few operations. Faults in mask gating or in the upper bits for 64-bit lanes appear as set bits in positions that must be zero, and these are checked on every returned result.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  typedef enum logic [2:0] {
    PRED_EQ     = 3'd0,
    PRED_LT     = 3'd1,
    PRED_LE     = 3'd2,
    PRED_NEVER  = 3'd3,
    PRED_NE     = 3'd4,
    PRED_GE     = 3'd5,
    PRED_GT     = 3'd6,
    PRED_ALWAYS = 3'd7
  } cmpPred_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;      // capture a new result this edge
    logic unmasked;  // selector decodes to "all lanes enabled"
  } ctrlStrobe_t;

  function automatic logic applyPred(input cmpPred_e code, input logic isEq, input logic isLt);
    logic hit;
    unique case (code)
      PRED_EQ:     hit = isEq;
      PRED_LT:     hit = isLt;
      PRED_LE:     hit = isLt | isEq;
      PRED_NEVER:  hit = 1'b0;
      PRED_NE:     hit = ~isEq;
      PRED_GE:     hit = ~isLt;
      PRED_GT:     hit = ~(isLt | isEq);
      default:     hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/vcmp_lane.sv
module vcmp_lane #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] opA,
  input  logic [LANE_W-1:0] opB,
  input  logic              cmpSigned,
  output logic              isEq,
  output logic              isLt
);
  logic ltSigned;
  logic ltUnsigned;

  assign ltSigned   = $signed(opA) < $signed(opB);
  assign ltUnsigned = opA < opB;
  assign isEq       = (opA == opB);
  assign isLt       = cmpSigned ? ltSigned : ltUnsigned;
endmodule

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl #(
  parameter int SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 outReady,
  input  logic [SEL_W-1:0]     maskSel,
  output logic                 inReady,
  output logic                 outValid,
  output vcmp_pkg::ctrlStrobe_t strobe
);
  logic validQ;

  assign inReady         = ~validQ | outReady;
  assign strobe.load     = inValid & inReady;
  assign strobe.unmasked = (maskSel == '0);
  assign outValid        = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/vcmp_datapath.sv
module vcmp_datapath #(
  parameter int VEC_W    = 512,
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64,
  localparam int NARROW_N = VEC_W / NARROW_W,
  localparam int WIDE_N   = VEC_W / WIDE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  vcmp_pkg::ctrlStrobe_t strobe,
  input  logic [VEC_W-1:0]      vecA,
  input  logic [VEC_W-1:0]      vecB,
  input  logic [2:0]            pred,
  input  logic                  laneWide,
  input  logic                  cmpSigned,
  input  logic [NARROW_N-1:0]   maskIn,
  output logic [NARROW_N-1:0]   outMask
);
  import vcmp_pkg::*;

  cmpPred_e            predCode;
  logic [NARROW_N-1:0] hitNarrow;
  logic [WIDE_N-1:0]   hitWide;
  logic [NARROW_N-1:0] laneEnable;
  logic [NARROW_N-1:0] nextMask;
  logic [NARROW_N-1:0] maskQ;

  assign predCode   = cmpPred_e'(pred);
  assign laneEnable = strobe.unmasked ? '1 : maskIn;

  for (genvar n = 0; n < NARROW_N; n++) begin : g_narrow
    logic eqN;
    logic ltN;
    vcmp_lane #(.LANE_W(NARROW_W)) u_lane (
      .opA       (vecA[n*NARROW_W +: NARROW_W]),
      .opB       (vecB[n*NARROW_W +: NARROW_W]),
      .cmpSigned (cmpSigned),
      .isEq      (eqN),
      .isLt      (ltN)
    );
    assign hitNarrow[n] = applyPred(predCode, eqN, ltN);
  end

  for (genvar w = 0; w < WIDE_N; w++) begin : g_wide
    logic eqW;
    logic ltW;
    vcmp_lane #(.LANE_W(WIDE_W)) u_lane (
      .opA       (vecA[w*WIDE_W +: WIDE_W]),
      .opB       (vecB[w*WIDE_W +: WIDE_W]),
      .cmpSigned (cmpSigned),
      .isEq      (eqW),
      .isLt      (ltW)
    );
    assign hitWide[w] = applyPred(predCode, eqW, ltW);
  end

  always_comb begin
    nextMask = '0;
    if (laneWide) begin
      nextMask[WIDE_N-1:0] = hitWide & laneEnable[WIDE_N-1:0];
    end else begin
      nextMask = hitNarrow & laneEnable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.load) begin
      maskQ <= nextMask;
    end
  end

  assign outMask = maskQ;
endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit #(
  parameter int VEC_W    = 512,
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64,
  parameter int SEL_W    = 3,
  localparam int MASK_W  = VEC_W / NARROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [VEC_W-1:0]  vecA,
  input  logic [VEC_W-1:0]  vecB,
  input  logic [2:0]        pred,
  input  logic              laneWide,
  input  logic              cmpSigned,
  input  logic [SEL_W-1:0]  maskSel,
  input  logic [MASK_W-1:0] maskIn,
  output logic              outValid,
  input  logic              outReady,
  output logic [MASK_W-1:0] outMask
);
  vcmp_pkg::ctrlStrobe_t strobe;

  vcmp_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .maskSel  (maskSel),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  vcmp_datapath #(
    .VEC_W    (VEC_W),
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .vecA      (vecA),
    .vecB      (vecB),
    .pred      (pred),
    .laneWide  (laneWide),
    .cmpSigned (cmpSigned),
    .maskIn    (maskIn),
    .outMask   (outMask)
  );
endmodule

// File: rtl/vcmp_mask_unit_chk.sv
module vcmp_mask_unit_chk #(
  parameter int MASK_W = 16,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [2:0]        pred,
  input logic              laneWide,
  input logic [SEL_W-1:0]  maskSel,
  input logic [MASK_W-1:0] maskIn,
  input logic              outValid,
  input logic              outReady,
  input logic [MASK_W-1:0] outMask
);
  localparam int HALF_W = MASK_W / 2;

  logic              capWide;
  logic [2:0]        capPred;
  logic [MASK_W-1:0] capEnable;
  logic              accept;

  assign accept = inValid & inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capWide   <= 1'b0;
      capPred   <= 3'd0;
      capEnable <= '0;
    end else if (accept) begin
      capWide   <= laneWide;
      capPred   <= pred;
      capEnable <= (maskSel == '0) ? '1 : maskIn;
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);

  p_stall_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outMask)));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && capWide) |-> (outMask[MASK_W-1:HALF_W] == '0));

  p_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outMask & ~capEnable) == '0));

  p_never_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && capPred == 3'd3) |-> (outMask == '0));

  p_always_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && capPred == 3'd7 && !capWide) |-> (outMask == capEnable));
endmodule

bind vcmp_mask_unit vcmp_mask_unit_chk #(.MASK_W(MASK_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .pred     (pred),
  .laneWide (laneWide),
  .maskSel  (maskSel),
  .maskIn   (maskIn),
  .outValid (outValid),
  .outReady (outReady),
  .outMask  (outMask)
);

// File: tb/tb_vcmp_mask_unit.sv
module tb_vcmp_mask_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [511:0] vecA = '0;
  logic [511:0] vecB = '0;
  logic [2:0]   pred = '0;
  logic         laneWide = 1'b0;
  logic         cmpSigned = 1'b0;
  logic [2:0]   maskSel = '0;
  logic [15:0]  maskIn = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [15:0]  outMask;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  bit          mValid = 0;
  logic [15:0] mMask = '0;
  string       mTag = "R8";

  // next operands prepared by the stimulus
  logic [511:0] nA;
  logic [511:0] nB;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcmp_mask_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .vecA(vecA), .vecB(vecB), .pred(pred), .laneWide(laneWide),
    .cmpSigned(cmpSigned), .maskSel(maskSel), .maskIn(maskIn),
    .outValid(outValid), .outReady(outReady), .outMask(outMask)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] refMask(logic [511:0] a, logic [511:0] b, int code,
                                          bit wide, bit sgn, int sel, logic [15:0] mk);
    logic [15:0] r = '0;
    int n = wide ? 8 : 16;
    for (int i = 0; i < n; i++) begin
      bit lt, eq, hit;
      if (wide) begin
        logic [63:0] x = a[64*i +: 64];
        logic [63:0] y = b[64*i +: 64];
        eq = (x == y);
        lt = sgn ? ($signed(x) < $signed(y)) : (x < y);
      end else begin
        logic [31:0] x = a[32*i +: 32];
        logic [31:0] y = b[32*i +: 32];
        eq = (x == y);
        lt = sgn ? ($signed(x) < $signed(y)) : (x < y);
      end
      case (code)
        0: hit = eq;
        1: hit = lt;
        2: hit = lt || eq;
        3: hit = 0;
        4: hit = !eq;
        5: hit = !lt;
        6: hit = !(lt || eq);
        default: hit = 1;
      endcase
      r[i] = hit && (sel == 0 || mk[i]);
    end
    return r;
  endfunction

  // One cycle: check outputs against the model, drive next inputs, advance model.
  task automatic step(string tag, bit v, bit rdy, int code, bit wide, bit sgn,
                      int sel, logic [15:0] mk);
    bit accept;
    @(negedge clk);
    if (mValid) begin
      chk("R8", {31'd0, outValid}, 32'd1);
      chk(mTag, {16'd0, outMask}, {16'd0, mMask});
    end else begin
      chk("R8", {31'd0, outValid}, 32'd0);
    end
    inValid = v; outReady = rdy; pred = code[2:0]; laneWide = wide;
    cmpSigned = sgn; maskSel = sel[2:0]; maskIn = mk; vecA = nA; vecB = nB;
    #1;
    chk("R9", {31'd0, inReady}, {31'd0, (!mValid || rdy)});
    accept = v && (!mValid || rdy);
    if (accept) begin
      mValid = 1;
      mMask = refMask(nA, nB, code, wide, sgn, sel, mk);
      mTag = tag;
    end else if (rdy) begin
      mValid = 0;
    end
  endtask

  // lanes cycle through equal / less / greater
  task automatic fillMixed(bit wide, bit neg);
    nA = '0; nB = '0;
    if (wide) begin
      for (int i = 0; i < 8; i++) begin
        logic [63:0] x = neg ? -64'(i + 7) : 64'(1000 + i);
        nA[64*i +: 64] = x;
        nB[64*i +: 64] = (i % 3 == 0) ? x : (i % 3 == 1) ? x + 64'd1 : x - 64'd1;
      end
    end else begin
      for (int i = 0; i < 16; i++) begin
        logic [31:0] x = neg ? -32'(i + 7) : 32'(500 + i);
        nA[32*i +: 32] = x;
        nB[32*i +: 32] = (i % 3 == 0) ? x : (i % 3 == 1) ? x + 32'd1 : x - 32'd1;
      end
    end
  endtask

  // a negative, b small positive: signed and unsigned disagree
  task automatic fillSignSplit(bit wide);
    nA = '0; nB = '0;
    for (int i = 0; i < (wide ? 8 : 16); i++) begin
      if (wide) begin
        nA[64*i +: 64] = 64'hFFFF_FFFF_FFFF_FFF0 + 64'(i);
        nB[64*i +: 64] = 64'(i);
      end else begin
        nA[32*i +: 32] = 32'hFFFF_FFF0 + 32'(i);
        nB[32*i +: 32] = 32'(i);
      end
    end
  endtask

  task automatic fillRandom();
    for (int j = 0; j < 8; j++) begin
      int r = $urandom % 4;
      nA[64*j +: 64] = {$urandom, $urandom};
      nB[64*j +: 64] = {$urandom, $urandom};
      if (r == 0) nB[64*j +: 64] = nA[64*j +: 64];
      if (r == 1) nB[64*j +: 32] = nA[64*j +: 32];
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finishRun();
  end

  initial begin
    nA = '0; nB = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R10", {31'd0, outValid}, 32'd0);
    chk("R10", {16'd0, outMask}, 32'd0);
    chk("R10", {31'd0, inReady}, 32'd1);

    // R1: every predicate code, unmasked, 32-bit unsigned (R2 lane layout)
    fillMixed(0, 0);
    for (int c = 0; c < 8; c++) step("R1", 1, 1, c, 0, 0, 0, 16'h0000);
    // R2: distinct lane data, explicit pattern
    for (int i = 0; i < 16; i++) begin
      nA[32*i +: 32] = 32'(i * 3);
      nB[32*i +: 32] = 32'(i * 2 + (i & 1) * 5);
    end
    step("R2", 1, 1, 1, 0, 0, 0, 16'h0);
    step("R2", 1, 1, 0, 0, 0, 0, 16'h0);
    // R3: 64-bit lanes, upper bits zero even with pred true
    fillMixed(1, 0);
    for (int c = 0; c < 8; c++) step("R3", 1, 1, c, 1, 0, 0, 16'hFFFF);
    // R4: signed vs unsigned in both widths
    fillSignSplit(0);
    step("R4", 1, 1, 1, 0, 1, 0, 16'h0);
    step("R4", 1, 1, 1, 0, 0, 0, 16'h0);
    fillSignSplit(1);
    step("R4", 1, 1, 6, 1, 1, 0, 16'h0);
    step("R4", 1, 1, 6, 1, 0, 0, 16'h0);
    fillMixed(0, 1);
    step("R4", 1, 1, 2, 0, 1, 0, 16'h0);
    // R5: nonzero selector gates lanes
    fillMixed(0, 0);
    step("R5", 1, 1, 7, 0, 0, 3, 16'hA5A5);
    step("R5", 1, 1, 4, 0, 0, 1, 16'h0F0F);
    fillMixed(1, 0);
    step("R5", 1, 1, 7, 1, 0, 5, 16'hFF3C);
    // R6: selector zero ignores maskIn
    fillMixed(0, 0);
    step("R6", 1, 1, 7, 0, 0, 0, 16'h0000);
    step("R6", 1, 1, 0, 0, 0, 0, 16'h1234);
    // R7: constant codes with operands irrelevant, still gated
    fillRandom();
    step("R7", 1, 1, 3, 0, 1, 0, 16'hFFFF);
    step("R7", 1, 1, 7, 0, 1, 2, 16'h8001);
    step("R7", 1, 1, 7, 1, 0, 0, 16'h0);
    // R9: stall the consumer and offer new work meanwhile
    fillMixed(0, 0);
    step("R9", 1, 0, 2, 0, 0, 0, 16'h0);
    fillRandom();
    step("R9", 1, 0, 5, 0, 0, 0, 16'h0);
    step("R9", 1, 0, 6, 1, 1, 4, 16'h00F7);
    step("R9", 1, 1, 6, 1, 1, 4, 16'h00F7);
    step("R8", 0, 1, 0, 0, 0, 0, 16'h0);
    step("R8", 0, 1, 0, 0, 0, 0, 16'h0);
    // mixed random traffic with random stalls
    for (int k = 0; k < 600; k++) begin
      fillRandom();
      step("R1", ($urandom % 4) != 0, ($urandom % 3) != 0, $urandom % 8,
           $urandom % 2, $urandom % 2, (($urandom % 3) == 0) ? 0 : ($urandom % 8),
           16'($urandom));
    end
    step("R8", 0, 1, 0, 0, 0, 0, 16'h0);
    step("R8", 0, 1, 0, 0, 0, 0, 16'h0);
    finishRun();
  end
endmodule